// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table that maps the segment part of an effective address to a virtual segment descriptor. Each of its `ENTRIES` slots holds two 64-bit words. The ESID word carries the segment bits and a valid flag. The VSID word carries a segment-size field, protection key bits, a no-execute bit, a class bit, a page-size code and the virtual segment ID. Each entry is compared either as a 256MB segment or as a 1TB segment, and the entry's own size field decides which.

Software fills the table through an indexed write port. That port rejects malformed descriptors and reports the rejection. Both words of any slot can be read back by index. A lookup port with a valid/ready handshake searches all entries at once. One cycle later it returns hit, index and descriptor, or all ones on a miss.

Entries are removed in two ways. An invalidate-by-address command clears the matching entry. An invalidate-all command walks the table one entry per clock while `busy` is high. A hint field selects which entries the walk touches. Both commands raise a local or global flush request for the translation caches downstream. When several commands arrive in the same cycle, a write wins over an invalidate-by-address, and that wins over an invalidate-all.

Top module: `seg_lb_array`

## Requirements
- R1: After reset every ESID and VSID word is zero, so every lookup misses. `busy`, `wr_err`, `rd_err`, `res_valid`, `flush_local`, `flush_global` and `hint_undef` are all low.
- R2: A write accepted at a clock edge stores `wr_rb` with bits 11:0 cleared as the ESID word, and stores `wr_vsid` unchanged as the VSID word, in slot `wr_rb[11:0]`. A read with `rd_en` returns slot `rd_rb[11:0]` on `rd_data` one cycle later: the ESID word when `rd_sel`=0, the VSID word when `rd_sel`=1.
- R3: A write is rejected in any of these cases: `wr_rb[11:0]` ≥ `ENTRIES`; any of `wr_rb[26:12]` is set; `wr_vsid[63]` is 1 (reserved size code); `wr_vsid[63:62]`=01 while `ONE_T_EN`=0; or the page-size code {`wr_vsid[8]`,`wr_vsid[5:4]`} selects a clear bit of `LLP_OK`. With the default, codes 0, 4, 5 and 6 are allowed. A rejected write leaves the table unchanged and pulses `wr_err` one cycle later.
- R4: A read with `rd_rb[11:0]` ≥ `ENTRIES` pulses `rd_err` one cycle later and returns zero.
- R5: Bit 27 of the ESID word is its valid flag. An entry with size code `vsid[63:62]`=00 hits when its ESID word equals {addr[63:28], 1, 27 zeros}. An entry with size code 01 hits when its ESID word equals {addr[63:40], 12 zeros, 1, 27 zeros}.
- R6: When several entries hit, `res_index` and `res_vsid` come from the lowest-index hit.
- R7: A miss gives `res_hit`=0 and `res_vsid` all ones. With `lk_mode64`=0, address bits 63:32 are treated as zero before the search.
- R8: `lk_ready` equals not `busy`. A lookup accepted at an edge produces `res_valid`=1 for exactly the next cycle, with its result held until the next accepted lookup.
- R9: Invalidate-by-address clears bit 27 of the lowest-index entry that hits on `inv_addr`, as in R5 without truncation. Only if an entry hit, it pulses `flush_global` (`inv_global`=1) or `flush_local` (`inv_global`=0) one cycle later.
- R10: An accepted invalidate-all always pulses `flush_local` one cycle later. Hint 7 changes nothing else. Every other hint clears bit 27 of each entry from a start slot to `ENTRIES`-1, and leaves the VSID words alone. The start slot is 0 for hints 3 and 4 and 1 otherwise. Hint 3 clears only entries whose class bit `vsid[7]` is 1.
- R11: Invalidate-all with hint 5 also pulses `hint_undef` one cycle later, and otherwise acts as the default hint.
- R12: A walk raises `busy` from the cycle after acceptance for `ENTRIES` minus start-slot cycles. While `busy` is high, writes, invalidates and lookups are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write command |
| wr_rb | input | 64 | Slot in bits 11:0, ESID word in bits 63:12 |
| wr_vsid | input | 64 | VSID word to store |
| wr_err | output | 1 | Write rejected (pulse) |
| rd_en | input | 1 | Indexed read command |
| rd_sel | input | 1 | 0 = ESID word, 1 = VSID word |
| rd_rb | input | 64 | Slot in bits 11:0 |
| rd_data | output | 64 | Read result |
| rd_err | output | 1 | Read slot out of range (pulse) |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | 64 | Effective address to look up |
| lk_mode64 | input | 1 | 0 = truncate the address to 32 bits |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | Lookup hit |
| res_index | output | IDX_W | Slot that hit |
| res_vsid | output | 64 | VSID word of the hit, all ones on a miss |
| inv_en | input | 1 | Invalidate-by-address command |
| inv_global | input | 1 | Request a global rather than a local flush |
| inv_addr | input | 64 | Address to invalidate |
| inva_en | input | 1 | Invalidate-all command |
| inva_hint | input | 3 | Invalidate-all hint |
| busy | output | 1 | Invalidate-all walk in progress |
| flush_local | output | 1 | Local flush request (pulse) |
| flush_global | output | 1 | Global flush request (pulse) |
| hint_undef | output | 1 | Undefined hint used (pulse) |

## Verification
Every result is registered exactly once. The lookup result, read data, write error, flush pulses and hint flag all appear in the cycle after the edge that accepts their command. During a walk, one entry is cleared at each edge, and `busy` falls after the edge that clears the last slot. The bench drives inputs on the falling edge. Its reference model advances on the rising edge, applying the same priority and acceptance rules. Every output is compared at the next falling edge, so each comparison lands in the cycle when the result is due.

// File: rtl/seg_lb_pkg.sv
package seg_lb_pkg;
   localparam int WORD_W    = 64;
   localparam int SLOT_W    = 12;
   localparam int VALID_BIT = 27;
   localparam int SEG_S_LSB = 28;
   localparam int SEG_L_LSB = 40;
   localparam int CLASS_BIT = 7;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [1:0] {
      SZ_256M = 2'b00,
      SZ_1T   = 2'b01,
      SZ_RSV2 = 2'b10,
      SZ_RSV3 = 2'b11
   } seg_size_e;

   localparam logic [2:0] HINT_NOP   = 3'd7;
   localparam logic [2:0] HINT_CLASS = 3'd3;
   localparam logic [2:0] HINT_FULL  = 3'd4;
   localparam logic [2:0] HINT_BAD   = 3'd5;

   // compare key for a 256MB segment
   function automatic word_t key_small(word_t a);
      return {a[WORD_W-1:SEG_S_LSB], 1'b1, {VALID_BIT{1'b0}}};
   endfunction

   // compare key for a 1TB segment
   function automatic word_t key_large(word_t a);
      return {a[WORD_W-1:SEG_L_LSB], {(SEG_L_LSB-SEG_S_LSB){1'b0}}, 1'b1,
              {VALID_BIT{1'b0}}};
   endfunction

   function automatic seg_size_e size_of(word_t v);
      return seg_size_e'(v[63:62]);
   endfunction

   function automatic logic [2:0] psz_code(word_t v);
      return {v[8], v[5:4]};
   endfunction
endpackage

// File: rtl/seg_lb_match.sv
module seg_lb_match
   import seg_lb_pkg::*;
#(
   parameter int ENTRIES = 32,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0][WORD_W-1:0] esid_tab,
   input  logic [ENTRIES-1:0][WORD_W-1:0] vsid_tab,
   input  word_t                          addr,
   output logic                           hit,
   output logic [IDX_W-1:0]               idx,
   output word_t                          vsid
);
   word_t ks, kl;
   logic [ENTRIES-1:0] hv;

   assign ks = key_small(addr);
   assign kl = key_large(addr);

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
         assign hv[i] = ((esid_tab[i] == ks) && (size_of(vsid_tab[i]) == SZ_256M)) ||
                        ((esid_tab[i] == kl) && (size_of(vsid_tab[i]) == SZ_1T));
      end
   endgenerate

   // lowest index wins: scan downward so the last assignment is the lowest
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hv[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

   assign vsid = hit ? vsid_tab[idx] : '1;
endmodule

// File: rtl/seg_lb_wcheck.sv
module seg_lb_wcheck
   import seg_lb_pkg::*;
#(
   parameter int         ENTRIES  = 32,
   parameter bit         ONE_T_EN = 1'b1,
   parameter logic [7:0] LLP_OK   = 8'h71,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  word_t            rb,
   input  word_t            vsid,
   output logic             ok,
   output logic [IDX_W-1:0] slot
);
   localparam logic [SLOT_W-1:0] LIMIT = SLOT_W'(ENTRIES);

   logic [SLOT_W-1:0] raw;
   logic in_range, esid_clean, size_ok, llp_ok;

   assign raw        = rb[SLOT_W-1:0];
   assign in_range   = raw < LIMIT;
   assign esid_clean = (rb[VALID_BIT-1:SLOT_W] == '0);
   assign llp_ok     = LLP_OK[psz_code(vsid)];

   generate
      if (ONE_T_EN) begin : g_big_seg
         assign size_ok = (size_of(vsid) == SZ_256M) || (size_of(vsid) == SZ_1T);
      end else begin : g_small_seg
         assign size_ok = (size_of(vsid) == SZ_256M);
      end
   endgenerate

   assign ok   = in_range && esid_clean && size_ok && llp_ok;
   assign slot = raw[IDX_W-1:0];
endmodule

// File: rtl/seg_lb_walker.sv
module seg_lb_walker #(
   parameter int ENTRIES = 32,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             from_zero,
   input  logic             class_only,
   output logic             busy,
   output logic [IDX_W-1:0] ptr,
   output logic             class_only_q
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy         <= 1'b0;
         ptr          <= '0;
         class_only_q <= 1'b0;
      end else if (start) begin
         busy         <= 1'b1;
         ptr          <= from_zero ? '0 : IDX_W'(1);
         class_only_q <= class_only;
      end else if (busy) begin
         if (ptr == LAST) busy <= 1'b0;
         else             ptr  <= ptr + 1'b1;
      end
   end

   // R12: walk advances one slot per clock and ends after the last slot
   a_r12_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ptr != LAST) |=> (busy && ptr == $past(ptr) + 1'b1));
   a_r12_walk_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ptr == LAST) |=> !busy);
endmodule

// File: rtl/seg_lb_array.sv
module seg_lb_array
   import seg_lb_pkg::*;
#(
   parameter int         ENTRIES  = 32,
   parameter bit         ONE_T_EN = 1'b1,
   parameter logic [7:0] LLP_OK   = 8'h71,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [63:0]      wr_rb,
   input  logic [63:0]      wr_vsid,
   output logic             wr_err,
   input  logic             rd_en,
   input  logic             rd_sel,
   input  logic [63:0]      rd_rb,
   output logic [63:0]      rd_data,
   output logic             rd_err,
   input  logic             lk_valid,
   output logic             lk_ready,
   input  logic [63:0]      lk_addr,
   input  logic             lk_mode64,
   output logic             res_valid,
   output logic             res_hit,
   output logic [IDX_W-1:0] res_index,
   output logic [63:0]      res_vsid,
   input  logic             inv_en,
   input  logic             inv_global,
   input  logic [63:0]      inv_addr,
   input  logic             inva_en,
   input  logic [2:0]       inva_hint,
   output logic             busy,
   output logic             flush_local,
   output logic             flush_global,
   output logic             hint_undef
);
   localparam logic [SLOT_W-1:0] LIMIT = SLOT_W'(ENTRIES);

   generate
      if (ENTRIES < 2 || ENTRIES > 2048) begin : g_bad_entries
         $error("seg_lb_array: ENTRIES must lie in 2..2048");
      end
   endgenerate

   logic [ENTRIES-1:0][WORD_W-1:0] esid_q, vsid_q;

   // ---- command acceptance and priority ----
   logic wr_acc, inv_acc, inva_acc, lk_acc;
   assign lk_ready = !busy;
   assign lk_acc   = lk_valid && !busy;
   assign wr_acc   = wr_en && !busy;
   assign inv_acc  = inv_en && !busy && !wr_en;
   assign inva_acc = inva_en && !busy && !wr_en && !inv_en;

   // ---- write validation ----
   logic             wr_ok;
   logic [IDX_W-1:0] wr_slot;
   seg_lb_wcheck #(.ENTRIES(ENTRIES), .ONE_T_EN(ONE_T_EN), .LLP_OK(LLP_OK)) u_wcheck (
      .rb(wr_rb), .vsid(wr_vsid), .ok(wr_ok), .slot(wr_slot)
   );

   // ---- associative search: lookup port and invalidate port ----
   word_t            lk_ea;
   logic             lk_hit, inv_hit;
   logic [IDX_W-1:0] lk_idx, inv_idx;
   word_t            lk_vsid, inv_vsid_unused;

   assign lk_ea = lk_mode64 ? lk_addr : {32'b0, lk_addr[31:0]};

   seg_lb_match #(.ENTRIES(ENTRIES)) u_lk_match (
      .esid_tab(esid_q), .vsid_tab(vsid_q), .addr(lk_ea),
      .hit(lk_hit), .idx(lk_idx), .vsid(lk_vsid)
   );
   seg_lb_match #(.ENTRIES(ENTRIES)) u_inv_match (
      .esid_tab(esid_q), .vsid_tab(vsid_q), .addr(inv_addr),
      .hit(inv_hit), .idx(inv_idx), .vsid(inv_vsid_unused)
   );

   // ---- invalidate-all walker ----
   logic             walk_start;
   logic [IDX_W-1:0] walk_ptr;
   logic             walk_class;
   assign walk_start = inva_acc && (inva_hint != HINT_NOP);

   seg_lb_walker #(.ENTRIES(ENTRIES)) u_walker (
      .clk(clk), .rst_n(rst_n), .start(walk_start),
      .from_zero((inva_hint == HINT_CLASS) || (inva_hint == HINT_FULL)),
      .class_only(inva_hint == HINT_CLASS),
      .busy(busy), .ptr(walk_ptr), .class_only_q(walk_class)
   );

   // ---- table storage ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         esid_q <= '0;
         vsid_q <= '0;
      end else if (busy) begin
         if (esid_q[walk_ptr][VALID_BIT] &&
             (!walk_class || vsid_q[walk_ptr][CLASS_BIT]))
            esid_q[walk_ptr][VALID_BIT] <= 1'b0;
      end else if (wr_acc && wr_ok) begin
         esid_q[wr_slot] <= {wr_rb[WORD_W-1:SLOT_W], {SLOT_W{1'b0}}};
         vsid_q[wr_slot] <= wr_vsid;
      end else if (inv_acc && inv_hit) begin
         esid_q[inv_idx][VALID_BIT] <= 1'b0;
      end
   end

   // ---- indexed read ----
   logic [SLOT_W-1:0] rd_raw;
   logic              rd_bad;
   assign rd_raw = rd_rb[SLOT_W-1:0];
   assign rd_bad = rd_raw >= LIMIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_err  <= 1'b0;
      end else begin
         rd_err <= rd_en && rd_bad;
         if (rd_en) begin
            if (rd_bad)      rd_data <= '0;
            else if (rd_sel) rd_data <= vsid_q[rd_raw[IDX_W-1:0]];
            else             rd_data <= esid_q[rd_raw[IDX_W-1:0]];
         end
      end
   end

   // ---- registered results and pulses ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_hit      <= 1'b0;
         res_index    <= '0;
         res_vsid     <= '0;
         wr_err       <= 1'b0;
         flush_local  <= 1'b0;
         flush_global <= 1'b0;
         hint_undef   <= 1'b0;
      end else begin
         res_valid <= lk_acc;
         if (lk_acc) begin
            res_hit   <= lk_hit;
            res_index <= lk_idx;
            res_vsid  <= lk_vsid;
         end
         wr_err       <= wr_acc && !wr_ok;
         flush_local  <= (inv_acc && inv_hit && !inv_global) || inva_acc;
         flush_global <= inv_acc && inv_hit && inv_global;
         hint_undef   <= inva_acc && (inva_hint == HINT_BAD);
      end
   end

   // R3: a write error only follows a write request
   a_r3_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en));
   // R4: a read error only follows a read request
   a_r4_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> $past(rd_en));
   // R8: a result strobe only follows an accepted request
   a_r8_result_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(lk_valid && lk_ready));
   // R9: a global flush only follows a global invalidate
   a_r9_global_after_inv: assert property (@(posedge clk) disable iff (!rst_n)
      flush_global |-> $past(inv_en && inv_global));
   // R11: the undefined-hint flag comes with a local flush
   a_r11_undef_with_flush: assert property (@(posedge clk) disable iff (!rst_n)
      hint_undef |-> flush_local);
   // R12: no walk starts without an invalidate-all request
   a_r12_busy_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(inva_en));
endmodule

// File: tb/seg_lb_array_tb_top.sv
module seg_lb_array_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int N = 32;
   localparam logic [63:0] V = 64'h0000_0000_0800_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        wr_en = 0, rd_en = 0, rd_sel = 0, lk_valid = 0, lk_mode64 = 1;
   logic        inv_en = 0, inv_global = 0, inva_en = 0;
   logic [2:0]  inva_hint = 0;
   logic [63:0] wr_rb = 0, wr_vsid = 0, rd_rb = 0, lk_addr = 0, inv_addr = 0;
   logic        wr_err, rd_err, lk_ready, res_valid, res_hit, busy;
   logic        flush_local, flush_global, hint_undef;
   logic [4:0]  res_index;
   logic [63:0] rd_data, res_vsid;

   seg_lb_array #(.ENTRIES(N)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_rb(wr_rb), .wr_vsid(wr_vsid), .wr_err(wr_err),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_rb(rd_rb), .rd_data(rd_data), .rd_err(rd_err),
      .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_mode64(lk_mode64),
      .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index), .res_vsid(res_vsid),
      .inv_en(inv_en), .inv_global(inv_global), .inv_addr(inv_addr),
      .inva_en(inva_en), .inva_hint(inva_hint),
      .busy(busy), .flush_local(flush_local), .flush_global(flush_global),
      .hint_undef(hint_undef)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [63:0] m_esid [N];
   logic [63:0] m_vsid [N];
   bit m_busy = 0, m_conly = 0;
   int m_ptr = 0;
   logic [63:0] e_rd_data = 0, e_res_vsid = 0;
   bit e_rd_err = 0, e_wr_err = 0, e_res_valid = 0, e_res_hit = 0;
   bit e_fl = 0, e_fg = 0, e_hu = 0, e_busy = 0;
   int e_res_index = 0;

   function automatic int m_find(logic [63:0] a);
      for (int i = 0; i < N; i++) begin
         if ((m_vsid[i][63:62] == 2'b00 && m_esid[i] == ((a & 64'hFFFF_FFFF_F000_0000) | V)) ||
             (m_vsid[i][63:62] == 2'b01 && m_esid[i] == ((a & 64'hFFFF_FF00_0000_0000) | V)))
            return i;
      end
      return -1;
   endfunction

   function automatic bit m_wr_ok(logic [63:0] rb, logic [63:0] v);
      int code;
      code = {v[8], v[5], v[4]};
      if (int'(rb[11:0]) >= N) return 0;
      if ((rb & 64'h0000_0000_07FF_F000) != 0) return 0;
      if (v[63]) return 0;
      if (!(code == 0 || code == 4 || code == 5 || code == 6)) return 0;
      return 1;
   endfunction

   initial for (int i = 0; i < N; i++) begin m_esid[i] = 0; m_vsid[i] = 0; end

   always @(posedge clk) begin
      int f, s;
      bit ob;
      logic [63:0] la;
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_esid[i] = 0; m_vsid[i] = 0; end
         m_busy = 0; m_ptr = 0; m_conly = 0;
         e_rd_data = 0; e_res_vsid = 0; e_rd_err = 0; e_wr_err = 0;
         e_res_valid = 0; e_res_hit = 0; e_res_index = 0;
         e_fl = 0; e_fg = 0; e_hu = 0; e_busy = 0;
      end else begin
         ob = m_busy;
         e_res_valid = 0;
         if (lk_valid && !ob) begin
            la = lk_mode64 ? lk_addr : (lk_addr & 64'h0000_0000_FFFF_FFFF);
            f = m_find(la);
            e_res_valid = 1;
            e_res_hit   = (f >= 0);
            e_res_index = (f >= 0) ? f : 0;
            e_res_vsid  = (f >= 0) ? m_vsid[f] : '1;
         end
         e_rd_err = 0;
         if (rd_en) begin
            s = int'(rd_rb[11:0]);
            if (s >= N) begin e_rd_err = 1; e_rd_data = 0; end
            else e_rd_data = rd_sel ? m_vsid[s] : m_esid[s];
         end
         e_wr_err = 0; e_fl = 0; e_fg = 0; e_hu = 0;
         if (ob) begin
            if (m_esid[m_ptr][27] && (!m_conly || m_vsid[m_ptr][7])) m_esid[m_ptr][27] = 0;
            if (m_ptr == N - 1) m_busy = 0; else m_ptr++;
         end else if (wr_en) begin
            if (m_wr_ok(wr_rb, wr_vsid)) begin
               m_esid[int'(wr_rb[11:0])] = {wr_rb[63:12], 12'h000};
               m_vsid[int'(wr_rb[11:0])] = wr_vsid;
            end else e_wr_err = 1;
         end else if (inv_en) begin
            f = m_find(inv_addr);
            if (f >= 0) begin
               m_esid[f][27] = 0;
               if (inv_global) e_fg = 1; else e_fl = 1;
            end
         end else if (inva_en) begin
            e_fl = 1;
            e_hu = (inva_hint == 3'd5);
            if (inva_hint != 3'd7) begin
               m_busy  = 1;
               m_ptr   = (inva_hint == 3'd3 || inva_hint == 3'd4) ? 0 : 1;
               m_conly = (inva_hint == 3'd3);
            end
         end
         e_busy = m_busy;
      end
   end

   // compare every output away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk("R2",  "rd_data",      rd_data,             e_rd_data);
         chk("R4",  "rd_err",       64'(rd_err),         64'(e_rd_err));
         chk("R3",  "wr_err",       64'(wr_err),         64'(e_wr_err));
         chk("R8",  "res_valid",    64'(res_valid),      64'(e_res_valid));
         chk("R5",  "res_hit",      64'(res_hit),        64'(e_res_hit));
         chk("R6",  "res_index",    64'(res_index),      64'(e_res_index));
         chk("R7",  "res_vsid",     res_vsid,            e_res_vsid);
         chk("R8",  "lk_ready",     64'(lk_ready),       64'(!e_busy));
         chk("R10", "flush_local",  64'(flush_local),    64'(e_fl));
         chk("R9",  "flush_global", 64'(flush_global),   64'(e_fg));
         chk("R11", "hint_undef",   64'(hint_undef),     64'(e_hu));
         chk("R12", "busy",         64'(busy),           64'(e_busy));
      end
   end

   // ---------------- stimulus tasks (drive on falling edge) ----------------
   task automatic wr(logic [63:0] rb, logic [63:0] v);
      wr_en = 1; wr_rb = rb; wr_vsid = v; @(negedge clk); wr_en = 0;
   endtask
   task automatic rd(logic [63:0] rb, logic sel);
      rd_en = 1; rd_rb = rb; rd_sel = sel; @(negedge clk); rd_en = 0;
   endtask
   task automatic lk(logic [63:0] a, logic m64);
      lk_valid = 1; lk_addr = a; lk_mode64 = m64; @(negedge clk); lk_valid = 0; lk_mode64 = 1;
   endtask
   task automatic inv(logic [63:0] a, logic g);
      inv_en = 1; inv_addr = a; inv_global = g; @(negedge clk); inv_en = 0;
   endtask
   task automatic inva(logic [2:0] h);
      inva_en = 1; inva_hint = h; @(negedge clk); inva_en = 0;
   endtask
   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [63:0] pool_addr(int k);
      return (64'(k % 4) << 40) | (64'(k / 4) << 28);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "busy_reset", 64'(busy), 64'd0);
      chk("R1", "flush_reset", 64'({flush_local, flush_global, hint_undef}), 64'd0);
      chk("R1", "res_reset", 64'({res_valid, res_hit}), 64'd0);
      rst_n = 1;
      @(negedge clk);
      rd(64'd5, 1'b0);                                      // R1: cleared word
      lk(64'h0000_0000_0000_0000, 1'b1);                    // R1: miss after reset

      // R2: valid writes of both segment sizes
      wr(64'h0000_0001_2000_0000 | V | 0,  64'h0000_0000_0123_4080);
      wr(64'h0000_0500_0000_0000 | V | 1,  64'h4000_0000_0567_0100);
      wr(64'h0000_0002_3000_0000 | V | 2,  64'h0000_0000_0abc_0080);
      wr(64'h0000_0003_4000_0000 | V | 3,  64'h0000_0000_0333_0000);
      wr(64'h0000_0003_4000_0000 | V | 5,  64'h0000_0000_0555_0110);
      wr(64'h0000_0000_3000_0000 | V | 6,  64'h0000_0000_0666_0120);
      wr(64'h0000_0123_4000_0000 | V | 7,  64'h4000_0000_0777_0000);
      // R3: rejected writes
      wr(64'h0000_0009_0000_0000 | V | 32, 64'h0);          // slot out of range
      wr(64'h0000_0009_0000_1000 | V | 8,  64'h0);          // bit 12 set
      wr(64'h0000_0009_0000_0000 | V | 8,  64'h8000_0000_0000_0000); // reserved size
      wr(64'h0000_0009_0000_0000 | V | 8,  64'h0000_0000_0000_0010); // page code 1
      rd(64'd8, 1'b0);                                      // R3: slot 8 untouched
      // R2 / R4: reads
      rd(64'd0, 1'b0); rd(64'd1, 1'b1);
      rd(64'hABCD_0000_0000_0003, 1'b1);
      rd(64'd40, 1'b0); rd(64'hFFF, 1'b1);
      // R5..R7: lookups
      lk(64'h0000_0001_2ABC_DEF0, 1'b1);
      lk(64'h0000_0500_FFFF_1234, 1'b1);
      lk(64'h0000_0003_4000_0008, 1'b1);                    // R6: slots 3 and 5 both hit
      lk(64'h0000_0123_4000_0000, 1'b1);                    // R7: miss
      lk(64'hFFFF_FFFF_3000_0010, 1'b0);                    // R7: truncated hit
      lk(64'hFFFF_FFFF_3000_0010, 1'b1);                    // R7: miss in 64-bit mode
      // R9: invalidate by address
      inv(64'h0000_0001_2000_0000, 1'b0);
      inv(64'h0000_0001_2000_0000, 1'b0);                   // already invalid: no flush
      inv(64'h0000_0500_1234_0000, 1'b1);
      lk(64'h0000_0001_2000_0000, 1'b1);
      rd(64'd1, 1'b0);
      // R10: hint 7 then default hint
      inva(3'd7);
      wr(64'h0000_0001_2000_0000 | V | 0,  64'h0000_0000_0123_4000);
      inva(3'd0);
      lk(64'h0000_0003_4000_0000, 1'b1);                    // R12: not accepted
      wr(64'h0000_0007_0000_0000 | V | 9,  64'h0);          // R12: ignored
      inv(64'h0000_0001_2000_0000, 1'b1);                   // R12: ignored
      wait_idle();
      rd(64'd0, 1'b0); rd(64'd9, 1'b0);
      lk(64'h0000_0001_2000_0000, 1'b1);
      // R10: class-only hint
      wr(64'h0000_0002_3000_0000 | V | 2,  64'h0000_0000_0abc_0080);
      wr(64'h0000_0003_4000_0000 | V | 3,  64'h0000_0000_0333_0000);
      wr(64'h0000_0004_0000_0000 | V | 0,  64'h0000_0000_0444_0080);
      inva(3'd3);
      wait_idle();
      rd(64'd0, 1'b0); rd(64'd2, 1'b0); rd(64'd3, 1'b0); rd(64'd2, 1'b1);
      // R11: undefined hint, then full hint
      wr(64'h0000_0002_3000_0000 | V | 0,  64'h0);
      wr(64'h0000_0002_4000_0000 | V | 4,  64'h0);
      inva(3'd5);
      wait_idle();
      rd(64'd0, 1'b0); rd(64'd4, 1'b0);
      inva(3'd4);
      wait_idle();
      rd(64'd0, 1'b0);

      // mixed traffic checked against the model every clock
      for (int c = 0; c < 2500; c++) begin
         int op, k;
         op = $urandom % 20;
         k  = $urandom % 8;
         wr_en = 0; rd_en = 0; lk_valid = 0; inv_en = 0; inva_en = 0;
         if (op < 6) begin
            logic [63:0] rb, v;
            rb = pool_addr(k) | (($urandom % 4 == 0) ? 64'h0 : V) | 64'($urandom % (N + 3));
            if ($urandom % 16 == 0) rb = rb | 64'h0000_0000_0000_4000;
            v = {$urandom, $urandom};
            v[63:62] = ($urandom % 10 == 0) ? 2'b10 : 2'($urandom % 2);
            case ($urandom % 5)
               0: {v[8], v[5], v[4]} = 3'd0;
               1: {v[8], v[5], v[4]} = 3'd4;
               2: {v[8], v[5], v[4]} = 3'd5;
               3: {v[8], v[5], v[4]} = 3'd6;
               default: {v[8], v[5], v[4]} = 3'($urandom);
            endcase
            wr_en = 1; wr_rb = rb; wr_vsid = v;
         end
         if (op >= 6 && op < 13) begin
            lk_valid = 1; lk_mode64 = ($urandom % 4 != 0);
            lk_addr = pool_addr(k) | 64'($urandom % 32'h1000_0000);
            if (!lk_mode64) lk_addr = lk_addr | 64'hFF00_0000_0000_0000;
         end
         if (op >= 10 && op < 16) begin
            rd_en = 1; rd_sel = 1'($urandom); rd_rb = 64'($urandom % (N + 4));
         end
         if (op >= 16 && op < 19) begin
            inv_en = 1; inv_global = 1'($urandom); inv_addr = pool_addr(k) | 64'($urandom % 256);
         end
         if (op == 19 && ($urandom % 4 == 0)) begin
            inva_en = 1; inva_hint = 3'($urandom);
         end
         @(negedge clk);
      end
      wr_en = 0; rd_en = 0; lk_valid = 0; inv_en = 0; inva_en = 0;
      wait_idle();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1ms;
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL R12 watchdog expired actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule